// File: doc/BRIEF.md
# Byte-Interleaved Receive Telecom Bus Formatter

This block takes a receive byte stream, one frame byte per bus clock, and presents it on a parallel telecom bus as an 8-bit data word with four companion signals: a payload-envelope flag, a composite sync that marks the J0, J1 and V1 bytes, a V1-only sync, and a parity bit. In the three-tributary mode, three STS-1/TUG-3 signals share the bus. Each tributary owns every third byte, so every overhead or marker position shows up as three consecutive bytes, tributary 0 first. In the single-tributary mode the same logic carries one STS-1, and the bus clock supplied to the block runs at one third of the rate.

The block keeps its own row, column and tributary count. A frame-start strobe realigns that count. The upstream pointer logic says which byte is J1, and a multiframe-phase input says when the V1 byte is due. The block derives the payload flag and the J0 position from its own count. It places the V1 marker, adds parity, and registers every output so that each marker appears in the same cycle as its data byte.

Top module: `tbus_fmt`

## Requirements
- R1: `o_data` equals the `i_data` byte accepted one clock earlier. While `rst_n` is low, every output is 0.
- R2: `o_par` makes the XOR of `o_data` and `o_par` equal to `cfg_odd`. With `cfg_odd`=1 the number of ones is odd; with `cfg_odd`=0 it is even.
- R3: The first byte after reset, and every byte presented with `i_fs`=1, is row 0, column 0. Columns count from 0. In the three-tributary mode the tributary of a byte is its column mod 3. `o_spe` is 1 exactly on columns 9 and above in the three-tributary mode.
- R4: `o_sync` is 1 on the J0 bytes: row 0, columns 6, 7 and 8 in the three-tributary mode, and row 0, column 2 in the single mode.
- R5: `o_sync` is 1 on any byte presented with `i_j1`=1 while `o_spe` is 1. An `i_j1` on a byte outside the payload envelope has no effect on any output.
- R6: When a J1 byte arrives with `i_mfph`=1, that tributary's next payload byte that is not itself J1 carries `o_v1`=1 and `o_sync`=1. In the three-tributary mode this byte is three bytes later, or after the overhead columns if the row wraps. A J1 byte that arrives with `i_mfph`=0 places no V1.
- R7: `o_v1` is never 1 on a byte where `o_spe` is 0, and never 1 on a byte where `o_sync` is 0.
- R8: With `cfg_sts1`=1 a row is 90 columns long and `o_spe` is 1 on columns 3 and above. Every byte belongs to tributary 0.
- R9: Without `i_fs`, the count wraps after 9 rows: 2430 bytes in the three-tributary mode and 810 bytes in the single mode. J0 then recurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, one byte per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sts1 | input | 1 | 1 selects the single-STS-1 geometry (static while running) |
| cfg_odd | input | 1 | 1 selects odd parity, 0 selects even |
| i_fs | input | 1 | Current byte is row 0, column 0 |
| i_j1 | input | 1 | Current byte is the J1 byte of its tributary |
| i_mfph | input | 1 | Multiframe phase: the next V1 is due after this J1 |
| i_data | input | 8 | Incoming frame byte |
| o_data | output | 8 | Bus data byte |
| o_spe | output | 1 | Byte belongs to the payload envelope |
| o_sync | output | 1 | Composite J0/J1/V1 marker |
| o_v1 | output | 1 | V1 marker |
| o_par | output | 1 | Parity over `o_data` |

## Verification
The checker tests the following relations on every cycle, since each can be seen in the port values of neighbouring cycles:
- the one-cycle data latency;
- the parity relation;
- that V1 is always inside the envelope and always carries the composite sync;
- that a frame-start byte is never in the envelope;
- that an in-envelope J1 raises the sync.

Other behaviour depends on frame geometry and can only be shown by the bench's long scenarios:
- the J0 column triplet;
- the exact V1 placement three bytes on, or across the overhead columns;
- an ignored J1 in the overhead;
- the 2430- and 810-byte wrap;
- realignment by a mid-frame strobe.

// File: rtl/tbus_fmt.sv
module tbus_fmt #(
  parameter int ROWS      = 9,
  parameter int STS1_COLS = 90,
  parameter int NTRIB     = 3,
  parameter int TOH_COLS  = 3,
  parameter int J0_COL    = 2,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_sts1,
  input  logic          cfg_odd,
  input  logic          i_fs,
  input  logic          i_j1,
  input  logic          i_mfph,
  input  logic [DW-1:0] i_data,
  output logic [DW-1:0] o_data,
  output logic          o_spe,
  output logic          o_sync,
  output logic          o_v1,
  output logic          o_par
);
  localparam int MAX_COLS = STS1_COLS * NTRIB;
  localparam int CW = $clog2(MAX_COLS);
  localparam int RW = $clog2(ROWS);
  localparam int TW = (NTRIB > 1) ? $clog2(NTRIB) : 1;
  localparam logic [CW-1:0] LAST_N = CW'(MAX_COLS - 1);
  localparam logic [CW-1:0] LAST_1 = CW'(STS1_COLS - 1);
  localparam logic [CW-1:0] SPE_N  = CW'(TOH_COLS * NTRIB);
  localparam logic [CW-1:0] SPE_1  = CW'(TOH_COLS);
  localparam logic [CW-1:0] J0_LO  = CW'(J0_COL * NTRIB);
  localparam logic [CW-1:0] J0_HI  = CW'((J0_COL + 1) * NTRIB);
  localparam logic [CW-1:0] J0_1   = CW'(J0_COL);
  localparam logic [RW-1:0] LAST_R = RW'(ROWS - 1);
  localparam logic [TW-1:0] LAST_T = TW'(NTRIB - 1);

  logic [CW-1:0]    col_q, col_c;
  logic [RW-1:0]    row_q, row_c;
  logic [TW-1:0]    trib_q, trib_c;
  logic             first_q;
  logic [NTRIB-1:0] pend_q;
  logic             spe_c, j0_c, j1_c, v1_c;
  logic [CW-1:0]    last_col;

  assign last_col = cfg_sts1 ? LAST_1 : LAST_N;

  always_comb begin
    col_c  = col_q + 1'b1;
    row_c  = row_q;
    trib_c = (cfg_sts1 || trib_q == LAST_T) ? '0 : trib_q + 1'b1;
    if (i_fs || first_q) begin
      col_c  = '0;
      row_c  = '0;
      trib_c = '0;
    end else if (col_q == last_col) begin
      col_c  = '0;
      row_c  = (row_q == LAST_R) ? '0 : row_q + 1'b1;
      trib_c = '0;
    end
  end

  assign spe_c = col_c >= (cfg_sts1 ? SPE_1 : SPE_N);
  assign j0_c  = (row_c == '0) &&
                 (cfg_sts1 ? (col_c == J0_1) : (col_c >= J0_LO && col_c < J0_HI));
  assign j1_c  = i_j1 && spe_c;
  assign v1_c  = spe_c && !j1_c && pend_q[trib_c];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      row_q   <= '0;
      trib_q  <= '0;
      first_q <= 1'b1;
    end else begin
      col_q   <= col_c;
      row_q   <= row_c;
      trib_q  <= trib_c;
      first_q <= 1'b0;
    end
  end

  for (genvar t = 0; t < NTRIB; t++) begin : g_pend
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pend_q[t] <= 1'b0;
      else if (trib_c == TW'(t)) begin
        if (j1_c)      pend_q[t] <= i_mfph;
        else if (v1_c) pend_q[t] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_data <= '0;
      o_spe  <= 1'b0;
      o_sync <= 1'b0;
      o_v1   <= 1'b0;
      o_par  <= 1'b0;
    end else begin
      o_data <= i_data;
      o_spe  <= spe_c;
      o_sync <= j0_c | j1_c | v1_c;
      o_v1   <= v1_c;
      o_par  <= (^i_data) ^ cfg_odd;
    end
  end
endmodule

module tbus_fmt_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_odd,
  input logic          i_fs,
  input logic          i_j1,
  input logic [DW-1:0] i_data,
  input logic [DW-1:0] o_data,
  input logic          o_spe,
  input logic          o_sync,
  input logic          o_v1,
  input logic          o_par
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  p_data_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> o_data == $past(i_data));
  p_parity_r2: assert property (@(posedge clk) disable iff (!rst_n)
    live |-> ((^o_data) ^ o_par) == $past(cfg_odd));
  p_fs_not_spe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(i_fs)) |-> !o_spe);
  p_j1_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(i_j1) && o_spe) |-> o_sync);
  p_v1_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    o_v1 |-> (o_spe && o_sync));
endmodule

bind tbus_fmt tbus_fmt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_odd(cfg_odd), .i_fs(i_fs), .i_j1(i_j1),
  .i_data(i_data), .o_data(o_data), .o_spe(o_spe), .o_sync(o_sync),
  .o_v1(o_v1), .o_par(o_par));

// File: tb/tbus_fmt_bench.sv
module tbus_fmt_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_sts1 = 1'b0, cfg_odd = 1'b0;
  logic i_fs = 1'b0, i_j1 = 1'b0, i_mfph = 1'b0;
  logic [7:0] i_data = '0;
  logic [7:0] o_data;
  logic o_spe, o_sync, o_v1, o_par;

  always #4 clk = ~clk;

  tbus_fmt u_tbus_fmt (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [11:0] expq[$];

  int m_row, m_col, m_trib;
  bit m_first;
  bit m_pend[3];

  function automatic bit want_j1(int r, int c);
    if (!cfg_sts1)
      return (r == 0 && c >= 30 && c <= 32) || (r == 2 && c >= 267) ||
             (r == 3 && c == 4) || (r == 5 && c == 100);
    return (r == 1 && c == 10) || (r == 4 && c == 89) || (r == 0 && c == 1);
  endfunction

  function automatic void model_reset();
    m_first = 1; m_row = 0; m_col = 0; m_trib = 0;
    foreach (m_pend[k]) m_pend[k] = 0;
  endfunction

  task automatic send(input bit fs);
    int lastc, col, row, trib;
    bit spe, j0, j1, j1e, v1e;
    logic [7:0] d;
    lastc = cfg_sts1 ? 89 : 269;
    if (fs || m_first) begin col = 0; row = 0; end
    else if (m_col == lastc) begin col = 0; row = (m_row == 8) ? 0 : m_row + 1; end
    else begin col = m_col + 1; row = m_row; end
    trib = cfg_sts1 ? 0 : col % 3;
    spe = col >= (cfg_sts1 ? 3 : 9);                                  // R3 R8
    j0  = row == 0 && (cfg_sts1 ? col == 2 : (col >= 6 && col <= 8)); // R4 R9
    j1  = want_j1(row, col);
    j1e = j1 && spe;                                                  // R5
    v1e = spe && !j1e && m_pend[trib];                                // R6
    if (j1e) m_pend[trib] = i_mfph; else if (v1e) m_pend[trib] = 0;
    d = 8'($urandom);
    expq.push_back({d, spe, j0 | j1e | v1e, v1e, ^d ^ cfg_odd});      // R1 R2
    m_first = 0; m_row = row; m_col = col; m_trib = trib;
    i_fs = fs; i_j1 = j1; i_data = d;
    @(negedge clk);
  endtask

  task automatic field(string tag, logic [7:0] act, logic [7:0] exp, ref bit bad);
    if (act !== exp) begin
      $display("FAIL %s: actual %0h expected %0h (row %0d col %0d)", tag, act, exp, m_row, m_col);
      bad = 1;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (expq.size() > 0) begin
        logic [11:0] e;
        bit bad;
        e = expq.pop_front();
        bad = 0;
        field("R1 data", o_data, e[11:4], bad);
        field("R3/R8 spe", {7'd0, o_spe}, {7'd0, e[3]}, bad);
        field("R4/R5/R9 sync", {7'd0, o_sync}, {7'd0, e[2]}, bad);
        field("R6/R7 v1", {7'd0, o_v1}, {7'd0, e[1]}, bad);
        field("R2 parity", {7'd0, o_par}, {7'd0, e[0]}, bad);
        n_chk++;
        if (bad) n_bad++;
      end
    end
  end

  task automatic check_reset();
    n_chk++;
    if ({o_data, o_spe, o_sync, o_v1, o_par} !== 12'd0) begin
      n_bad++;
      $display("FAIL R1 reset: actual %0h expected 0", {o_data, o_spe, o_sync, o_v1, o_par});
    end
  endtask

  task automatic start(bit sts1, bit odd);
    @(negedge clk);
    rst_n = 0; i_fs = 0; i_j1 = 0;
    cfg_sts1 = sts1; cfg_odd = odd;
    repeat (2) @(negedge clk);
    check_reset();
    model_reset();
    rst_n = 1;
  endtask

  initial begin
    start(0, 0);
    i_mfph = 1;
    for (int k = 0; k < 2430; k++) send(k == 0);
    i_mfph = 0;
    for (int k = 0; k < 2430; k++) send(0);
    i_mfph = 1;
    for (int k = 0; k < 1000; k++) send(0);
    for (int k = 0; k < 2430; k++) send(k == 0);
    start(1, 1);
    for (int k = 0; k < 810; k++) send(k == 0);
    i_mfph = 0;
    for (int k = 0; k < 810; k++) send(0);
    i_mfph = 1;
    for (int k = 0; k < 500; k++) send(0);
    for (int k = 0; k < 900; k++) send(k == 0);
    @(negedge clk);
    i_fs = 0; i_j1 = 0;
    repeat (2) @(negedge clk);
    if (expq.size() != 0) begin
      n_bad++;
      $display("FAIL R1 drain: actual %0d expected 0", expq.size());
    end
    n_chk++;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule